// File: doc/BRIEF.md
# Single-Byte Target Data Buffers

This block sits between a CPU-side register interface and the byte engine of a serial bus target. It holds one byte that the CPU writes for the bus to read, and one byte that the bus writes for the CPU to read. Two status flags show whether each slot can take its next access. The transmit slot reports empty and the receive slot reports full.

Any access that breaks the buffer rules leaves the stored data untouched and raises an error strobe for one clock. Each of the four possible misuses has its own strobe: a CPU write into a loaded transmit slot, a CPU read from an unloaded receive slot, a bus read from an empty transmit slot, and a bus write into a loaded receive slot. The block also counts the bytes of a private write, starting from a transaction-start strobe. It compares that count with a programmable maximum length and flags every byte beyond the limit.

Top module: `tgt_byte_buffers`

## Requirements
- R1: After reset, txEmpty is 1, rxFull is 0 and all five error strobes are 0.
- R2: A CPU write while txEmpty is 1 stores cpuWrData and drives txEmpty to 0 from the next cycle. While txEmpty is 0, busRdData shows the stored byte. A bus read request then sets txEmpty back to 1 on the next cycle.
- R3: A CPU write while txEmpty is 0 raises txWriteErr in the next cycle. The stored byte is not changed, so a later bus read returns the earlier byte.
- R4: A bus write while rxFull is 0 stores busWrData and drives rxFull to 1 from the next cycle, with the byte on cpuRdData. A CPU read then clears rxFull on the next cycle without raising rxReadErr.
- R5: A CPU read while rxFull is 0 raises rxReadErr in the next cycle, and rxFull stays 0.
- R6: While txEmpty is 1, busRdData is all ones (8'hFF at the default width). A bus read request in that state raises txUnderrun in the next cycle.
- R7: A bus write while rxFull is 1 raises rxOverrun in the next cycle. The incoming byte is dropped and cpuRdData keeps the byte already held.
- R8: A byte counter counts bus writes that have privWrite at 1. When maxWrLen is nonzero, each such byte that arrives after maxWrLen bytes of the current transaction raises wrLenOverflow in the next cycle.
- R9: When maxWrLen is 0, wrLenOverflow never rises.
- R10: xferStart resets the byte counter to zero. A private byte in the same cycle counts as the first byte. The counter saturates at its maximum value and does not wrap, so overflow stays flagged past 2^LEN_W bytes.
- R11: Every error strobe is high for exactly one cycle per offending access. An access held for two cycles gives two pulses, and the strobe is low again once the access stops.
- R12: Bus writes with privWrite at 0 are not counted toward the maximum length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuWrEn | input | 1 | CPU writes the transmit byte this cycle |
| cpuWrData | input | DATA_W | Byte written by the CPU |
| cpuRdEn | input | 1 | CPU reads the receive byte this cycle |
| cpuRdData | output | DATA_W | Held receive byte |
| txEmpty | output | 1 | Transmit slot can take a CPU write |
| rxFull | output | 1 | Receive slot holds an unread byte |
| busRdReq | input | 1 | Bus engine consumes the transmit byte this cycle |
| busRdData | output | DATA_W | Transmit byte, or all ones when empty |
| busWrEn | input | 1 | Bus engine delivers a received byte this cycle |
| busWrData | input | DATA_W | Byte delivered by the bus engine |
| privWrite | input | 1 | Current bus write belongs to a private write |
| xferStart | input | 1 | Start of a new transaction; clears the byte count |
| maxWrLen | input | LEN_W | Maximum private write length; 0 disables the check |
| txWriteErr | output | 1 | CPU wrote a loaded transmit slot |
| rxReadErr | output | 1 | CPU read an unloaded receive slot |
| txUnderrun | output | 1 | Bus read an empty transmit slot |
| rxOverrun | output | 1 | Bus wrote a loaded receive slot |
| wrLenOverflow | output | 1 | Private write went past maxWrLen |

## Verification
The status flags and all five strobes are registered, so each one reflects an access one clock edge after that access. busRdData and cpuRdData are combinational from the held state and change only after an edge that loads or consumes a slot. The bench drives each access on a falling edge and removes it on the next falling edge. It reads the registered results at that second falling edge. It reads busRdData one time unit after the request is driven, before the consuming edge. Strobe width is checked by sampling again one cycle later.

// File: rtl/tgt_buf_pkg.sv
package tgt_buf_pkg;
  // load strobes from control to datapath
  typedef struct packed {
    logic txLoad;
    logic rxLoad;
  } bufStrobe_t;
endpackage

// File: rtl/tgt_buf_ctrl.sv
module tgt_buf_ctrl
  import tgt_buf_pkg::*;
#(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cpuWrEn,
  input  logic             cpuRdEn,
  input  logic             busRdReq,
  input  logic             busWrEn,
  input  logic             privWrite,
  input  logic             xferStart,
  input  logic [LEN_W-1:0] maxWrLen,
  output bufStrobe_t       strb,
  output logic             txEmpty,
  output logic             rxFull,
  output logic             txWriteErr,
  output logic             rxReadErr,
  output logic             txUnderrun,
  output logic             rxOverrun,
  output logic             wrLenOverflow
);
  localparam logic [LEN_W-1:0] CNT_MAX = {LEN_W{1'b1}};

  logic [LEN_W-1:0] wrCount, cntBase, wrCountNext;
  logic             privByte, overLimit;
  logic             txEmptyNext, rxFullNext;

  always_comb begin
    strb.txLoad = cpuWrEn && txEmpty;
    strb.rxLoad = busWrEn && !rxFull;

    txEmptyNext = txEmpty;
    if (txEmpty && cpuWrEn)        txEmptyNext = 1'b0;
    else if (!txEmpty && busRdReq) txEmptyNext = 1'b1;

    rxFullNext = rxFull;
    if (!rxFull && busWrEn)        rxFullNext = 1'b1;
    else if (rxFull && cpuRdEn)    rxFullNext = 1'b0;

    privByte  = busWrEn && privWrite;
    cntBase   = xferStart ? '0 : wrCount;
    overLimit = privByte && (maxWrLen != '0) && (cntBase >= maxWrLen);
    if (privByte) wrCountNext = (cntBase == CNT_MAX) ? CNT_MAX : cntBase + 1'b1;
    else          wrCountNext = cntBase;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txEmpty       <= 1'b1;
      rxFull        <= 1'b0;
      wrCount       <= '0;
      txWriteErr    <= 1'b0;
      rxReadErr     <= 1'b0;
      txUnderrun    <= 1'b0;
      rxOverrun     <= 1'b0;
      wrLenOverflow <= 1'b0;
    end else begin
      txEmpty       <= txEmptyNext;
      rxFull        <= rxFullNext;
      wrCount       <= wrCountNext;
      txWriteErr    <= cpuWrEn && !txEmpty;
      rxReadErr     <= cpuRdEn && !rxFull;
      txUnderrun    <= busRdReq && txEmpty;
      rxOverrun     <= busWrEn && rxFull;
      wrLenOverflow <= overLimit;
    end
  end

  // R2: a write into an empty slot leaves it loaded next cycle
  p_tx_load_r2: assert property (@(posedge clk) disable iff (!rstN)
    (cpuWrEn && txEmpty) |=> !txEmpty);
  // R3: a write into a loaded slot is reported
  p_tx_wr_err_r3: assert property (@(posedge clk) disable iff (!rstN)
    (cpuWrEn && !txEmpty) |=> txWriteErr);
  // R4: a bus write into an unloaded slot leaves it full
  p_rx_load_r4: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && !rxFull) |=> rxFull);
  // R5: reading an unloaded slot is reported and it stays unloaded
  p_rd_err_r5: assert property (@(posedge clk) disable iff (!rstN)
    (cpuRdEn && !rxFull && !busWrEn) |=> (rxReadErr && !rxFull));
  // R6: bus read of an empty slot is reported
  p_underrun_r6: assert property (@(posedge clk) disable iff (!rstN)
    (busRdReq && txEmpty) |=> txUnderrun);
  // R7: bus write into a full slot is reported and the slot stays full
  p_overrun_r7: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && rxFull && !cpuRdEn) |=> (rxOverrun && rxFull));
  // R9: zero maximum length never flags
  p_zero_len_r9: assert property (@(posedge clk) disable iff (!rstN)
    (maxWrLen == '0) |=> !wrLenOverflow);
  // R10: a saturated count stays saturated until a new start
  p_sat_r10: assert property (@(posedge clk) disable iff (!rstN)
    (wrCount == CNT_MAX && !xferStart) |=> (wrCount == CNT_MAX));
  // R11: a strobe is only present right after its own access
  p_one_cycle_r11: assert property (@(posedge clk) disable iff (!rstN)
    txUnderrun |-> $past(busRdReq));
endmodule

// File: rtl/tgt_buf_data.sv
module tgt_buf_data
  import tgt_buf_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  bufStrobe_t        strb,
  input  logic              txEmpty,
  input  logic [DATA_W-1:0] cpuWrData,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] cpuRdData,
  output logic [DATA_W-1:0] busRdData
);
  localparam logic [DATA_W-1:0] UNDERRUN_FILL = {DATA_W{1'b1}};

  logic [DATA_W-1:0] txByte, rxByte;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txByte <= '0;
      rxByte <= '0;
    end else begin
      if (strb.txLoad) txByte <= cpuWrData;
      if (strb.rxLoad) rxByte <= busWrData;
    end
  end

  assign cpuRdData = rxByte;
  assign busRdData = txEmpty ? UNDERRUN_FILL : txByte;

  // R3: the transmit byte only changes on an accepted load
  p_tx_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    !strb.txLoad |=> $stable(txByte));
  // R7: the receive byte only changes on an accepted load
  p_rx_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    !strb.rxLoad |=> $stable(rxByte));
endmodule

// File: rtl/tgt_byte_buffers.sv
module tgt_byte_buffers
  import tgt_buf_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int LEN_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuWrEn,
  input  logic [DATA_W-1:0] cpuWrData,
  input  logic              cpuRdEn,
  output logic [DATA_W-1:0] cpuRdData,
  output logic              txEmpty,
  output logic              rxFull,
  input  logic              busRdReq,
  output logic [DATA_W-1:0] busRdData,
  input  logic              busWrEn,
  input  logic [DATA_W-1:0] busWrData,
  input  logic              privWrite,
  input  logic              xferStart,
  input  logic [LEN_W-1:0]  maxWrLen,
  output logic              txWriteErr,
  output logic              rxReadErr,
  output logic              txUnderrun,
  output logic              rxOverrun,
  output logic              wrLenOverflow
);
  bufStrobe_t strb;

  tgt_buf_ctrl #(.LEN_W(LEN_W)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .cpuWrEn(cpuWrEn), .cpuRdEn(cpuRdEn),
    .busRdReq(busRdReq), .busWrEn(busWrEn),
    .privWrite(privWrite), .xferStart(xferStart), .maxWrLen(maxWrLen),
    .strb(strb), .txEmpty(txEmpty), .rxFull(rxFull),
    .txWriteErr(txWriteErr), .rxReadErr(rxReadErr),
    .txUnderrun(txUnderrun), .rxOverrun(rxOverrun),
    .wrLenOverflow(wrLenOverflow)
  );

  tgt_buf_data #(.DATA_W(DATA_W)) u_data (
    .clk(clk), .rstN(rstN), .strb(strb), .txEmpty(txEmpty),
    .cpuWrData(cpuWrData), .busWrData(busWrData),
    .cpuRdData(cpuRdData), .busRdData(busRdData)
  );
endmodule

// File: tb/tgt_byte_buffers_test.sv
module tgt_byte_buffers_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN;
  logic       cpuWrEn, cpuRdEn, busRdReq, busWrEn, privWrite, xferStart;
  logic [7:0] cpuWrData, busWrData, maxWrLen;
  logic [7:0] cpuRdData, busRdData;
  logic       txEmpty, rxFull, txWriteErr, rxReadErr, txUnderrun, rxOverrun, wrLenOverflow;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tgt_byte_buffers uut (
    .clk(clk), .rstN(rstN),
    .cpuWrEn(cpuWrEn), .cpuWrData(cpuWrData), .cpuRdEn(cpuRdEn), .cpuRdData(cpuRdData),
    .txEmpty(txEmpty), .rxFull(rxFull),
    .busRdReq(busRdReq), .busRdData(busRdData), .busWrEn(busWrEn), .busWrData(busWrData),
    .privWrite(privWrite), .xferStart(xferStart), .maxWrLen(maxWrLen),
    .txWriteErr(txWriteErr), .rxReadErr(rxReadErr), .txUnderrun(txUnderrun),
    .rxOverrun(rxOverrun), .wrLenOverflow(wrLenOverflow)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic idle();
    cpuWrEn = 0; cpuRdEn = 0; busRdReq = 0; busWrEn = 0; xferStart = 0; privWrite = 0;
  endtask

  // one-cycle accesses: drive on a falling edge, release on the next
  task automatic cpuWrite(input logic [7:0] d);
    @(negedge clk); cpuWrEn = 1; cpuWrData = d;
    @(negedge clk); cpuWrEn = 0;
  endtask

  task automatic cpuRead();
    @(negedge clk); cpuRdEn = 1;
    @(negedge clk); cpuRdEn = 0;
  endtask

  task automatic busRead(output logic [7:0] seen);
    @(negedge clk); busRdReq = 1; #1 seen = busRdData;
    @(negedge clk); busRdReq = 0;
  endtask

  task automatic busWrite(input logic [7:0] d, input logic priv);
    @(negedge clk); busWrEn = 1; busWrData = d; privWrite = priv;
    @(negedge clk); busWrEn = 0; privWrite = 0;
  endtask

  task automatic startXfer();
    @(negedge clk); xferStart = 1;
    @(negedge clk); xferStart = 0;
  endtask

  task automatic t_reset();
    chk("R1", "txEmpty", txEmpty, 1);
    chk("R1", "rxFull", rxFull, 0);
    chk("R1", "errors", {txWriteErr, rxReadErr, txUnderrun, rxOverrun, wrLenOverflow}, 0);
  endtask

  task automatic t_tx_basic();
    logic [7:0] seen;
    cpuWrite(8'h5A);
    chk("R2", "txEmpty after write", txEmpty, 0);
    chk("R2", "no write error", txWriteErr, 0);
    busRead(seen);
    chk("R2", "busRdData", seen, 8'h5A);
    chk("R2", "txEmpty after consume", txEmpty, 1);
    chk("R2", "no underrun", txUnderrun, 0);
  endtask

  task automatic t_tx_write_err();
    logic [7:0] seen;
    cpuWrite(8'hA1);
    cpuWrite(8'hB2);
    chk("R3", "txWriteErr", txWriteErr, 1);
    @(negedge clk);
    chk("R11", "txWriteErr one cycle", txWriteErr, 0);
    busRead(seen);
    chk("R3", "byte kept", seen, 8'hA1);
  endtask

  task automatic t_underrun();
    logic [7:0] seen;
    busRead(seen);
    chk("R6", "fill byte", seen, 8'hFF);
    chk("R6", "txUnderrun", txUnderrun, 1);
    @(negedge clk);
    chk("R11", "txUnderrun one cycle", txUnderrun, 0);
  endtask

  task automatic t_rx_basic();
    busWrite(8'h3C, 0);
    chk("R4", "rxFull", rxFull, 1);
    chk("R4", "cpuRdData", cpuRdData, 8'h3C);
    cpuRead();
    chk("R4", "rxFull cleared", rxFull, 0);
    chk("R4", "no read error", rxReadErr, 0);
  endtask

  task automatic t_rd_err();
    cpuRead();
    chk("R5", "rxReadErr", rxReadErr, 1);
    chk("R5", "rxFull stays low", rxFull, 0);
  endtask

  task automatic t_overrun();
    busWrite(8'h11, 0);
    busWrite(8'h22, 0);
    chk("R7", "rxOverrun", rxOverrun, 1);
    chk("R7", "held byte", cpuRdData, 8'h11);
    @(negedge clk);
    chk("R11", "rxOverrun one cycle", rxOverrun, 0);
    cpuRead();
  endtask

  task automatic t_held_access();
    @(negedge clk); cpuRdEn = 1;
    @(negedge clk);
    chk("R11", "first pulse", rxReadErr, 1);
    @(negedge clk); cpuRdEn = 0;
    chk("R11", "second pulse", rxReadErr, 1);
    @(negedge clk);
    chk("R11", "low after release", rxReadErr, 0);
  endtask

  task automatic t_overflow();
    maxWrLen = 8'd3;
    startXfer();
    for (int i = 0; i < 3; i++) begin
      busWrite(8'(i), 1);
      chk("R8", "within limit", wrLenOverflow, 0);
    end
    busWrite(8'h44, 1);
    chk("R8", "fourth byte overflows", wrLenOverflow, 1);
    busWrite(8'h55, 1);
    chk("R8", "fifth byte overflows", wrLenOverflow, 1);
    startXfer();
    for (int i = 0; i < 3; i++) busWrite(8'(i), 1);
    chk("R10", "start clears count", wrLenOverflow, 0);
    startXfer();
    for (int i = 0; i < 4; i++) busWrite(8'(i), 0);
    busWrite(8'h66, 1);
    chk("R12", "non-private not counted", wrLenOverflow, 0);
    cpuRead();
  endtask

  task automatic t_zero_len();
    maxWrLen = 8'd0;
    startXfer();
    for (int i = 0; i < 6; i++) begin
      busWrite(8'(i), 1);
      chk("R9", "disabled check", wrLenOverflow, 0);
    end
    cpuRead();
  endtask

  task automatic t_saturate();
    int early = 0;
    maxWrLen = 8'd255;
    // start and first private byte in the same cycle
    @(negedge clk); xferStart = 1; busWrEn = 1; privWrite = 1; busWrData = 8'h00;
    @(negedge clk); xferStart = 0; busWrEn = 0; privWrite = 0;
    early += wrLenOverflow;
    for (int i = 1; i < 255; i++) begin
      busWrite(8'(i), 1);
      early += wrLenOverflow;
    end
    chk("R10", "no flag up to limit", early, 0);
    busWrite(8'hAA, 1);
    chk("R10", "byte 256 overflows", wrLenOverflow, 1);
    busWrite(8'hBB, 1);
    chk("R10", "byte 257 still overflows", wrLenOverflow, 1);
    cpuRead();
  endtask

  initial begin
    idle(); cpuWrData = 0; busWrData = 0; maxWrLen = 0;
    rstN = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    t_reset();
    t_tx_basic();
    t_tx_write_err();
    t_underrun();
    t_rx_basic();
    t_rd_err();
    t_overrun();
    t_held_access();
    t_overflow();
    t_zero_len();
    t_saturate();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule